// File: doc/BRIEF.md
# Veto Length Recorder

This block watches the sources that together form the acquisition veto: the trigger pulse, the readout dead time, the ADC busy and the QDC busy. Their OR is the combined veto. A rising edge of the trigger, taken while measurement is enabled, opens a record window. During that window one saturating counter per source, plus one for the combined veto, counts the clock cycles in which its signal is high. The window closes on the first cycle in which the combined veto is low. The five counts are then written as a five-word record into an on-chip FIFO.

A host drains the FIFO one 32-bit word at a time. The data port always shows the oldest word, and a read strobe pops it. A status word reports the fill level, full and empty flags, and two flags around a fixed mark of 4000 words. Control inputs enable measurement, abandon the record in progress and clear its counters, and empty the FIFO.

Top module: `vetoLengthRecorder`

## Requirements
- R1: A trigger rising edge seen while idle with measurement enabled produces one record of five words, in the order trigger, dead time, ADC busy, QDC busy, combined veto. Bits 31..29 of each word hold the codes 1, 2, 3, 4 and 5 respectively.
- R2: Bits 28..0 of a word hold the number of cycles its signal was high, counted from the trigger edge cycle through the last cycle of the combined veto. The combined-veto word therefore holds the window length.
- R3: A further trigger rising edge inside an open window starts no new record, and its high cycles add to the trigger count.
- R4: Each count saturates at 2^CNT_W-1 and does not wrap.
- R5: With measurement disabled, no record starts. Disabling measurement inside an open window abandons that record, and nothing is written.
- R6: A pulse on the counter clear input abandons the record in progress and zeroes the counters, and no words of that record are written.
- R7: If fewer than five free entries remain when a window closes, the whole record is dropped and the fill level does not change.
- R8: Status bits 12..0 give the number of stored words (at most DEPTH, default 4095). Bit 16 is set when the FIFO is full and bit 17 is set when it is empty.
- R9: Status bit 19 is set when fewer than 4000 words are stored, and bit 18 is set when more than 4000 words are stored.
- R10: The data port shows the oldest stored word, and a read strobe removes it. With the FIFO empty, the data port reads 0 and a strobe changes nothing.
- R11: A pulse on the FIFO clear input empties the FIFO by the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (one tick per count unit) |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | 1 | Trigger pulse |
| deadIn | input | 1 | Readout dead time |
| adcBusyIn | input | 1 | ADC busy |
| qdcBusyIn | input | 1 | QDC busy |
| measEn | input | 1 | Measurement enable |
| cntClr | input | 1 | Abandon the record and clear the counters (pulse) |
| fifoClr | input | 1 | Empty the FIFO (pulse) |
| rdStb | input | 1 | Pop the word shown on rdData |
| rdData | output | 32 | Oldest FIFO word, or 0 when empty |
| status | output | 32 | Fill count and level flags |

## Verification
The hardest state to reach is a nearly full FIFO, where the record-drop rule and the 4000-word flags come into play. The stimulus fires several hundred one-cycle triggers back to back and samples the flags at 3995, 4000 and 4005 words. It then fills the FIFO to 4095 words. Triggers are then fired with zero free entries and again with one free entry, and the fill level must stay where it is. Saturation cannot be reached with the default 29-bit counter, so a second instance with 5-bit counters receives the same long window.

// File: rtl/vlrPkg.sv
package vlrPkg;
  localparam int NUM_WORDS = 5;
  localparam int CODE_W    = 3;
  localparam int FIELD_W   = 29;
  localparam int STAT_CW   = 13;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MEAS,
    ST_WRITE
  } vlrState_e;

  typedef struct packed {
    logic       start;
    logic       count;
    logic       clrCnt;
    logic       push;
    logic [2:0] wordSel;
  } vlrStrobe_t;
endpackage

// File: rtl/vlrControl.sv
module vlrControl
  import vlrPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       trig,
  input  logic       vetoAny,
  input  logic       measEn,
  input  logic       cntClr,
  input  logic       fifoClr,
  input  logic       roomOk,
  output vlrStrobe_t strobe
);
  vlrState_e  state, stateNext;
  logic [2:0] wordIdx;
  logic       trigPrev;
  logic       trigEdge;

  assign trigEdge = trig && !trigPrev;

  always_comb begin
    stateNext      = state;
    strobe         = '0;
    strobe.wordSel = wordIdx;
    if (cntClr) begin
      strobe.clrCnt = 1'b1;
      stateNext     = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (measEn && trigEdge) begin
            strobe.start = 1'b1;
            stateNext    = ST_MEAS;
          end
        end
        ST_MEAS: begin
          if (!measEn) begin
            stateNext = ST_IDLE;
          end else if (vetoAny) begin
            strobe.count = 1'b1;
          end else begin
            stateNext = roomOk ? ST_WRITE : ST_IDLE;
          end
        end
        ST_WRITE: begin
          if (fifoClr) begin
            stateNext = ST_IDLE;
          end else begin
            strobe.push = 1'b1;
            if (wordIdx == 3'(NUM_WORDS - 1)) stateNext = ST_IDLE;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      wordIdx  <= '0;
      trigPrev <= 1'b0;
    end else begin
      state    <= stateNext;
      trigPrev <= trig;
      if (strobe.push) wordIdx <= wordIdx + 3'd1;
      else             wordIdx <= '0;
    end
  end
endmodule

// File: rtl/vlrDatapath.sv
module vlrDatapath
  import vlrPkg::*;
#(
  parameter int DEPTH = 4095,
  parameter int CNT_W = 29,
  parameter int MARK  = 4000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  srcVec,
  input  vlrStrobe_t  strobe,
  input  logic        fifoClr,
  input  logic        rdStb,
  output logic        vetoAny,
  output logic        roomOk,
  output logic [31:0] rdData,
  output logic [31:0] status
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_CW = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_CW-1:0] MARK_C = CNT_CW'(MARK);
  localparam logic [CNT_CW-1:0] FULL_C = CNT_CW'(DEPTH);
  localparam logic [CNT_CW-1:0] ROOM_C = CNT_CW'(DEPTH - NUM_WORDS);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);

  logic [NUM_WORDS-1:0] hit;
  logic [CNT_W-1:0]     cnt [NUM_WORDS];

  assign vetoAny = |srcVec;

  generate
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_ctr
      if (i == NUM_WORDS - 1) begin : g_total
        assign hit[i] = vetoAny;
      end else begin : g_src
        assign hit[i] = srcVec[i];
      end
      always_ff @(posedge clk) begin
        if (!rstN || strobe.clrCnt) begin
          cnt[i] <= '0;
        end else if (strobe.start) begin
          cnt[i] <= CNT_W'(hit[i]);
        end else if (strobe.count && hit[i] && cnt[i] != CNT_MAX) begin
          cnt[i] <= cnt[i] + 1'b1;
        end
      end
    end
  endgenerate

  logic [31:0]       mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_CW-1:0] fillCnt;
  logic [31:0]       wrWord;
  logic              doWrite, doRead, isEmpty, isFull;

  assign wrWord  = {CODE_W'(strobe.wordSel + 3'd1), FIELD_W'(cnt[strobe.wordSel])};
  assign isEmpty = (fillCnt == '0);
  assign isFull  = (fillCnt == FULL_C);
  assign doWrite = strobe.push && !fifoClr && !isFull;
  assign doRead  = rdStb && !fifoClr && !isEmpty;
  assign roomOk  = (fillCnt <= ROOM_C);

  always_ff @(posedge clk) begin
    if (doWrite) mem[wrPtr] <= wrWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN || fifoClr) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fillCnt <= '0;
    end else begin
      if (doWrite) wrPtr <= (wrPtr == LAST_P) ? '0 : wrPtr + 1'b1;
      if (doRead)  rdPtr <= (rdPtr == LAST_P) ? '0 : rdPtr + 1'b1;
      if (doWrite && !doRead)      fillCnt <= fillCnt + 1'b1;
      else if (doRead && !doWrite) fillCnt <= fillCnt - 1'b1;
    end
  end

  assign rdData = isEmpty ? 32'd0 : mem[rdPtr];

  always_comb begin
    status             = '0;
    status[STAT_CW-1:0] = STAT_CW'(fillCnt);
    status[16]         = isFull;
    status[17]         = isEmpty;
    status[18]         = (fillCnt > MARK_C);
    status[19]         = (fillCnt < MARK_C);
  end
endmodule

// File: rtl/vetoLengthRecorder.sv
module vetoLengthRecorder
  import vlrPkg::*;
#(
  parameter int DEPTH = 4095,
  parameter int CNT_W = 29,
  parameter int MARK  = 4000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        trigIn,
  input  logic        deadIn,
  input  logic        adcBusyIn,
  input  logic        qdcBusyIn,
  input  logic        measEn,
  input  logic        cntClr,
  input  logic        fifoClr,
  input  logic        rdStb,
  output logic [31:0] rdData,
  output logic [31:0] status
);
  vlrStrobe_t strobe;
  logic       vetoAny;
  logic       roomOk;

  vlrControl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .trig    (trigIn),
    .vetoAny (vetoAny),
    .measEn  (measEn),
    .cntClr  (cntClr),
    .fifoClr (fifoClr),
    .roomOk  (roomOk),
    .strobe  (strobe)
  );

  vlrDatapath #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .MARK  (MARK)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .srcVec  ({qdcBusyIn, adcBusyIn, deadIn, trigIn}),
    .strobe  (strobe),
    .fifoClr (fifoClr),
    .rdStb   (rdStb),
    .vetoAny (vetoAny),
    .roomOk  (roomOk),
    .rdData  (rdData),
    .status  (status)
  );
endmodule

// File: rtl/vlrChecker.sv
module vlrChecker #(
  parameter int DEPTH = 4095
) (
  input logic        clk,
  input logic        rstN,
  input logic        fifoClr,
  input logic        rdStb,
  input logic [31:0] rdData,
  input logic [31:0] status
);
  logic [12:0] fill;
  assign fill = status[12:0];

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fill <= 13'(DEPTH));

  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(status[19] && status[18]));

  // R10
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    status[17] |-> rdData == 32'd0);

  // R10
  step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fifoClr |=> (fill == $past(fill) || fill == $past(fill) + 13'd1
                  || fill == $past(fill) - 13'd1));

  // R11
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoClr |=> fill == 13'd0);

  // R1
  code_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    !status[17] |-> (rdData[31:29] >= 3'd1 && rdData[31:29] <= 3'd5));
endmodule

bind vetoLengthRecorder vlrChecker #(.DEPTH(DEPTH)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .fifoClr (fifoClr),
  .rdStb   (rdStb),
  .rdData  (rdData),
  .status  (status)
);

// File: tb/sim_vetoLengthRecorder.sv
module sim_vetoLengthRecorder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigIn = 0, deadIn = 0, adcBusyIn = 0, qdcBusyIn = 0;
  logic measEn = 0, cntClr = 0, fifoClr = 0, rdStb = 0, rdStb1 = 0;
  logic [31:0] rdData, status, rdData1, status1;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  logic [31:0] expQ[$];
  bit [3:0]    pat[$];
  int          lastCnt[5];

  always #10 clk = ~clk;

  vetoLengthRecorder u0 (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .deadIn(deadIn),
    .adcBusyIn(adcBusyIn), .qdcBusyIn(qdcBusyIn), .measEn(measEn),
    .cntClr(cntClr), .fifoClr(fifoClr), .rdStb(rdStb),
    .rdData(rdData), .status(status)
  );

  vetoLengthRecorder #(.CNT_W(5)) u1 (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .deadIn(deadIn),
    .adcBusyIn(adcBusyIn), .qdcBusyIn(qdcBusyIn), .measEn(measEn),
    .cntClr(cntClr), .fifoClr(fifoClr), .rdStb(rdStb1),
    .rdData(rdData1), .status(status1)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bit 0 trigger, 1 dead time, 2 ADC busy, 3 QDC busy
  task automatic addPulse(input int b, input int off, input int len);
    while (pat.size() < off + len) pat.push_back(4'b0);
    for (int k = off; k < off + len; k++) begin
      bit [3:0] t;
      t = pat[k];
      t[b] = 1'b1;
      pat[k] = t;
    end
  endtask

  // driver: plays the pattern and pushes the expected record
  task automatic fire(input bit keep, input int clrAt, input int offAt);
    bit ended = 0;
    for (int w = 0; w < 5; w++) lastCnt[w] = 0;
    for (int i = 0; i < pat.size(); i++) begin
      @(negedge clk);
      {qdcBusyIn, adcBusyIn, deadIn, trigIn} = pat[i];
      cntClr = (i == clrAt);
      if (i == offAt) measEn = 1'b0;
      if (!ended) begin
        if (pat[i] != 4'b0) begin
          for (int b = 0; b < 4; b++) lastCnt[b] += int'(pat[i][b]);
          lastCnt[4]++;
        end else begin
          ended = 1;
        end
      end
    end
    @(negedge clk);
    {qdcBusyIn, adcBusyIn, deadIn, trigIn} = 4'b0;
    cntClr = 1'b0;
    repeat (8) @(negedge clk);
    if (keep)
      for (int w = 0; w < 5; w++) expQ.push_back({3'(w + 1), 29'(lastCnt[w])});
    pat.delete();
  endtask

  // monitor: pops one word and compares it against the scoreboard
  task automatic readOne(input string req);
    logic [31:0] e;
    @(negedge clk);
    e = (expQ.size() > 0) ? expQ.pop_front() : 32'hFFFF_FFFF;
    check(req, rdData, e);
    rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0;
  endtask

  task automatic drain(input string req);
    @(negedge clk);
    check({req, " fill"}, 32'(status[12:0]), 32'(expQ.size()));
    while (status[17] == 1'b0 && expQ.size() > 0) readOne(req);
  endtask

  task automatic pulseFifoClr();
    @(negedge clk);
    fifoClr = 1'b1;
    @(negedge clk);
    fifoClr = 1'b0;
    expQ.delete();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 R9 reset state: empty and almost-empty only
    check("R8 R9 reset status", status, 32'h000A_0000);
    measEn = 1'b1;

    // R1 R2 lone trigger
    addPulse(0, 0, 3);
    fire(1, -1, -1);
    drain("R1 R2 lone trigger");

    // R2 overlapping sources
    addPulse(0, 0, 2); addPulse(1, 0, 6); addPulse(2, 1, 4); addPulse(3, 3, 8);
    fire(1, -1, -1);
    drain("R2 overlap");

    // R2 staggered chain
    addPulse(0, 0, 1); addPulse(2, 1, 3); addPulse(3, 4, 2); addPulse(1, 5, 7);
    fire(1, -1, -1);
    drain("R2 chain");

    // R3 second trigger edge inside the window
    addPulse(0, 0, 2); addPulse(1, 0, 10); addPulse(0, 5, 3);
    fire(1, -1, -1);
    drain("R3 retrigger");

    // R5 disabled: nothing recorded
    measEn = 1'b0;
    addPulse(0, 0, 2); addPulse(1, 0, 4);
    fire(0, -1, -1);
    check("R5 disabled fill", 32'(status[12:0]), 32'd0);
    measEn = 1'b1;

    // R5 disabled inside window
    addPulse(0, 0, 1); addPulse(1, 0, 10);
    fire(0, -1, 4);
    check("R5 abandon fill", 32'(status[12:0]), 32'd0);
    measEn = 1'b1;

    // R6 counter clear inside window, then a clean record
    addPulse(0, 0, 1); addPulse(1, 0, 10);
    fire(0, 4, -1);
    check("R6 clear fill", 32'(status[12:0]), 32'd0);
    addPulse(0, 0, 2); addPulse(2, 1, 3);
    fire(1, -1, -1);
    drain("R6 after clear");

    // R4 saturation on the narrow instance
    pulseFifoClr();
    addPulse(0, 0, 40); addPulse(1, 2, 45);
    fire(1, -1, -1);
    for (int w = 0; w < 5; w++) begin
      @(negedge clk);
      check("R4 saturate", rdData1, {3'(w + 1), 29'((lastCnt[w] > 31) ? 31 : lastCnt[w])});
      rdStb1 = 1'b1;
      @(negedge clk);
      rdStb1 = 1'b0;
    end
    drain("R4 wide count");

    // R9 R8 R7 fill to the top
    pulseFifoClr();
    for (int r = 1; r <= 819; r++) begin
      addPulse(0, 0, 1);
      fire(0, -1, -1);
      if (r == 799) check("R9 below mark", {30'd0, status[19:18]}, 32'd2);
      if (r == 800) check("R9 at mark", status, 32'h0000_0FA0);
      if (r == 801) check("R9 above mark", {30'd0, status[19:18]}, 32'd1);
    end
    check("R8 full", status, 32'h0005_0FFF);
    addPulse(0, 0, 1);
    fire(0, -1, -1);
    check("R7 drop when full", 32'(status[12:0]), 32'd4095);
    @(negedge clk);
    check("R10 head word", rdData, {3'd1, 29'd1});
    rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0;
    addPulse(0, 0, 1);
    fire(0, -1, -1);
    check("R7 drop one free", 32'(status[12:0]), 32'd4094);

    // R11 clear, R10 read while empty
    pulseFifoClr();
    check("R11 cleared", status, 32'h000A_0000);
    @(negedge clk);
    check("R10 empty data", rdData, 32'd0);
    rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0;
    @(negedge clk);
    check("R10 empty read", status, 32'h000A_0000);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end
endmodule